// File: doc/BRIEF.md
# Pipeline No-op Kill Controller

This block is the small control machine for a five-stage in-order pipeline (fetch, register read, execute, memory, write-back) in which a branch resolves at the end of execute. Because the branch outcome arrives that late, the two instructions behind it have already been fetched; these are its two delay slots. The controller decides, cycle by cycle, which instructions sitting in the pipe must be turned into no-ops. Three causes feed it: a squashing branch that turns out not taken, an exception raised against the instruction in execute, and reset.

Each no-op decision is raised in the cycle where its cause appears. A mark then travels with the instruction down the stages, so one kill vector reports, for every stage, whether the instruction now in that stage is a no-op. The write-back register-file write and the memory-stage access start are gated by that vector. After synchronous reset is released, fetch stays killed for a parameterised number of cycles and the marks loaded during reset drain out stage by stage, so start-up is deterministic.

Top module: `squash_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, every bit of kill_o is 1 and both rf_wr_en and mem_acc_en are 0, whatever the other inputs are. kill_o bit 0 is fetch, bit 1 register read, bit 2 execute, bit 3 memory, bit 4 write-back.
- R2: Counting the first cycle with rst_n high as cycle 0, and with no branch or exception events, kill_o bit s is 1 in cycles 0 through s+1 (fetch-kill hold of 2 cycles) and 0 afterwards.
- R3: In a cycle with br_resolve=1, br_squash_en=1 and br_taken=0, kill_o bits 0 and 1 (the two delay slots) are 1 in that same cycle.
- R4: A resolving branch that is taken, or that has br_squash_en=0, adds no kill: in that cycle kill_o bits 0 and 1 reflect only marks already present.
- R5: An instruction killed in stage s in one cycle is killed in stage s+1 in the next cycle, up to write-back, while reset stays high.
- R6: In a cycle with exc_req=1, kill_o bits 0, 1 and 2 are 1; bits 3 and 4 carry only marks already present.
- R7: When exc_req and an untaken squashing branch resolve in the same cycle, the kill pattern is the union of both (bits 0 to 2 set), and the following cycles follow R5 from that pattern.
- R8: rf_wr_en is 1 exactly when wb_wr_req is 1 and kill_o bit 4 is 0; mem_acc_en is 1 exactly when mem_acc_req is 1 and kill_o bit 3 is 0.
- R9: While br_resolve is 0, br_taken and br_squash_en have no effect on kill_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_resolve | input | 1 | A branch in execute resolves this cycle |
| br_taken | input | 1 | Resolved branch is taken |
| br_squash_en | input | 1 | Resolved branch asks for its slots to be squashed when not taken |
| exc_req | input | 1 | Exception raised against the instruction in execute |
| wb_wr_req | input | 1 | Instruction in write-back wants to write the register file |
| mem_acc_req | input | 1 | Instruction in memory stage wants to start an access |
| kill_o | output | 5 | Per-stage no-op flags, bit 0 fetch to bit 4 write-back |
| rf_wr_en | output | 1 | Gated register-file write enable |
| mem_acc_en | output | 1 | Gated memory-access start |

## Verification
The bench targets the post-reset drain, where a controller that forgot the reset marks or the fetch hold would let a stale write-back or memory access through in the first few cycles. It drives exceptions and untaken squashes in the same cycle, where a design that chose one cause over the other would leave the execute stage or a slot alive. Taken and non-squashing branches, and flag toggling without a resolve strobe, catch a decoder that kills too eagerly. Back-to-back squashes and long random runs check that marks move exactly one stage per cycle: a pipe that dropped or duplicated a mark would gate the wrong write.

// File: rtl/squash_pkg.sv
// Package: shared defaults and stage naming for the no-op kill controller.
// Assumes an in-order pipe where stage index grows toward write-back.
package squash_pkg;

    localparam int unsigned SQ_STAGES     = 5;  // fetch .. write-back
    localparam int unsigned SQ_SLOTS      = 2;  // delay slots behind a branch
    localparam int unsigned SQ_EXC_DEPTH  = 3;  // stages flushed by an exception
    localparam int unsigned SQ_RST_HOLD   = 2;  // fetch kills after reset release

    typedef enum logic [2:0] {
        STG_FETCH = 3'd0,
        STG_REGRD = 3'd1,
        STG_EXEC  = 3'd2,
        STG_MEMAC = 3'd3,
        STG_WBACK = 3'd4
    } sq_stage_e;

endpackage

// File: rtl/sq_event_decode.sv
// Module: sq_event_decode
// Turns this cycle's branch and exception events into a fresh kill mask.
// Assumes the resolving branch and the excepting instruction sit in execute,
// so only younger stages (lower index) and execute itself can be hit.
module sq_event_decode #(
    parameter int unsigned NSTG      = 5,
    parameter int unsigned SLOTS     = 2,
    parameter int unsigned EXC_DEPTH = 3
) (
    input  logic            br_resolve,
    input  logic            br_taken,
    input  logic            br_squash_en,
    input  logic            exc_req,
    output logic [NSTG-1:0] fresh_o
);

    logic squash_hit;

    // An untaken branch that asked for squashing hits its delay slots.
    assign squash_hit = br_resolve && br_squash_en && !br_taken;

    // Per-stage union of both causes; depth comparison is fixed per stage.
    for (genvar g = 0; g < NSTG; g++) begin : g_stg
        localparam bit IN_SLOT = (g < SLOTS);
        localparam bit IN_EXC  = (g < EXC_DEPTH);
        assign fresh_o[g] = (IN_SLOT && squash_hit) || (IN_EXC && exc_req);
    end

endmodule

// File: rtl/sq_fetch_hold.sv
// Module: sq_fetch_hold
// Keeps fetch killed for HOLD cycles after synchronous reset is released.
// Assumes HOLD >= 1 so the instruction fetched on release is never trusted.
module sq_fetch_hold #(
    parameter int unsigned HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold_o
);

    localparam int unsigned CW = $clog2(HOLD + 1);

    logic [CW-1:0] left_q;

    // Count down the remaining post-reset fetch kills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= CW'(HOLD);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign hold_o = (left_q != '0);

endmodule

// File: rtl/sq_mark_pipe.sv
// Module: sq_mark_pipe
// Carries each stage's no-op decision one stage further per clock.
// Assumes the pipe advances every cycle (no stalls); reset marks every stage.
module sq_mark_pipe #(
    parameter int unsigned NSTG = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] kill_i,
    output logic [NSTG-1:0] marks_o
);

    logic [NSTG-1:1] mark_q;

    // One flop per stage past fetch, fed by the previous stage's kill.
    for (genvar g = 1; g < NSTG; g++) begin : g_mark
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q[g] <= 1'b1;
            end else begin
                mark_q[g] <= kill_i[g-1];
            end
        end
    end

    // Fetch never inherits a mark: a new instruction enters it each cycle.
    assign marks_o = {mark_q, 1'b0};

endmodule

// File: rtl/squash_ctrl.sv
// Module: squash_ctrl (top)
// Merges squash, exception and reset no-op causes into one per-stage kill
// vector and gates register-file writes and memory-access starts with it.
// Assumes a non-stalling pipe, branch/exception seen in execute, and a
// synchronous active-low reset held for at least one clock.
module squash_ctrl
    import squash_pkg::*;
#(
    parameter int unsigned NSTG      = SQ_STAGES,
    parameter int unsigned SLOTS     = SQ_SLOTS,
    parameter int unsigned EXC_DEPTH = SQ_EXC_DEPTH,
    parameter int unsigned RST_HOLD  = SQ_RST_HOLD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_resolve,
    input  logic            br_taken,
    input  logic            br_squash_en,
    input  logic            exc_req,
    input  logic            wb_wr_req,
    input  logic            mem_acc_req,
    output logic [NSTG-1:0] kill_o,
    output logic            rf_wr_en,
    output logic            mem_acc_en
);

    localparam int unsigned WB_IDX  = NSTG - 1;
    localparam int unsigned MEM_IDX = NSTG - 2;

    logic [NSTG-1:0] fresh;
    logic [NSTG-1:0] marks;
    logic [NSTG-1:0] hold_vec;
    logic            hold;

    sq_event_decode #(
        .NSTG      (NSTG),
        .SLOTS     (SLOTS),
        .EXC_DEPTH (EXC_DEPTH)
    ) u_decode (
        .br_resolve   (br_resolve),
        .br_taken     (br_taken),
        .br_squash_en (br_squash_en),
        .exc_req      (exc_req),
        .fresh_o      (fresh)
    );

    sq_fetch_hold #(
        .HOLD (RST_HOLD)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_o (hold)
    );

    sq_mark_pipe #(
        .NSTG (NSTG)
    ) u_marks (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill_i  (kill_o),
        .marks_o (marks)
    );

    assign hold_vec = {{(NSTG-1){1'b0}}, hold};

    // Final per-stage kill: everything during reset, else union of causes.
    always_comb begin
        if (!rst_n) begin
            kill_o = '1;
        end else begin
            kill_o = marks | fresh | hold_vec;
        end
    end

    // Killed instructions may neither write registers nor start an access.
    assign rf_wr_en   = wb_wr_req   && !kill_o[WB_IDX];
    assign mem_acc_en = mem_acc_req && !kill_o[MEM_IDX];

endmodule

// File: rtl/squash_ctrl_chk.sv
// Module: squash_ctrl_chk
// Property checker for squash_ctrl, attached with the bind at file end.
// Assumes the same parameters as the bound instance.
module squash_ctrl_chk #(
    parameter int unsigned NSTG      = 5,
    parameter int unsigned EXC_DEPTH = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_resolve,
    input logic            br_taken,
    input logic            br_squash_en,
    input logic            exc_req,
    input logic            wb_wr_req,
    input logic            mem_acc_req,
    input logic [NSTG-1:0] kill_o,
    input logic            rf_wr_en,
    input logic            mem_acc_en
);

    // Reset forces a full flush and blocks all side effects.
    assert_reset_flush_R1: assert property (@(posedge clk)
        !rst_n |-> (&kill_o && !rf_wr_en && !mem_acc_en));

    // Untaken squashing branch kills both delay slots at once.
    assert_squash_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve && br_squash_en && !br_taken) |-> (kill_o[0] && kill_o[1]));

    // Without a squash or exception, register-read only inherits fetch's kill.
    assert_no_extra_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !exc_req && !(br_resolve && br_squash_en && !br_taken))
        |-> (kill_o[1] == $past(kill_o[0])));

    // Exceptions flush the young stages up to execute.
    assert_exc_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (&kill_o[EXC_DEPTH-1:0]));

    // Simultaneous exception and squash give the union pattern.
    assert_union_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && br_resolve && br_squash_en && !br_taken)
        |-> (&kill_o[EXC_DEPTH-1:0]));

    // A no-op mark moves one stage per clock.
    for (genvar g = 0; g < NSTG - 1; g++) begin : g_travel
        assert_mark_travel_R5: assert property (@(posedge clk) disable iff (!rst_n)
            kill_o[g] |=> kill_o[g+1]);
    end

    // Gated enables never let a killed instruction act.
    assert_wb_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (wb_wr_req && !kill_o[NSTG-1]));

    assert_mem_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_acc_en |-> (mem_acc_req && !kill_o[NSTG-2]));

endmodule

bind squash_ctrl squash_ctrl_chk #(
    .NSTG      (NSTG),
    .EXC_DEPTH (EXC_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_resolve   (br_resolve),
    .br_taken     (br_taken),
    .br_squash_en (br_squash_en),
    .exc_req      (exc_req),
    .wb_wr_req    (wb_wr_req),
    .mem_acc_req  (mem_acc_req),
    .kill_o       (kill_o),
    .rf_wr_en     (rf_wr_en),
    .mem_acc_en   (mem_acc_en)
);

// File: tb/test_squash_ctrl.sv
// Bench: behavioural per-cycle model of which pipe slots hold no-ops,
// compared against squash_ctrl outputs once per clock.
module test_squash_ctrl;

    localparam int TCLK     = 10;
    localparam int NSTG     = 5;
    localparam int RST_HOLD = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            br_resolve = 1'b0;
    logic            br_taken = 1'b0;
    logic            br_squash_en = 1'b0;
    logic            exc_req = 1'b0;
    logic            wb_wr_req = 1'b0;
    logic            mem_acc_req = 1'b0;
    logic [NSTG-1:0] kill_o;
    logic            rf_wr_en;
    logic            mem_acc_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model: queue of "is a no-op" flags for stages past fetch, oldest last.
    bit mq[$];
    int hold_left;

    always #(TCLK/2) clk = ~clk;

    squash_ctrl i_squash_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_resolve   (br_resolve),
        .br_taken     (br_taken),
        .br_squash_en (br_squash_en),
        .exc_req      (exc_req),
        .wb_wr_req    (wb_wr_req),
        .mem_acc_req  (mem_acc_req),
        .kill_o       (kill_o),
        .rf_wr_en     (rf_wr_en),
        .mem_acc_en   (mem_acc_en)
    );

    function automatic logic [NSTG-1:0] model_kill();
        logic [NSTG-1:0] k;
        if (!rst_n) return '1;
        k = '0;
        for (int s = 1; s < NSTG; s++) k[s] = mq[s-1];
        if (hold_left > 0) k[0] = 1'b1;
        if (br_resolve && br_squash_en && !br_taken) begin
            k[0] = 1'b1;
            k[1] = 1'b1;
        end
        if (exc_req) begin
            k[0] = 1'b1;
            k[1] = 1'b1;
            k[2] = 1'b1;
        end
        return k;
    endfunction

    // Called just after a falling edge with inputs set: compare, then advance.
    task automatic step(input string tag);
        logic [NSTG-1:0] ek;
        logic erf, emem;
        #1;
        ek   = model_kill();
        erf  = wb_wr_req && !ek[NSTG-1];
        emem = mem_acc_req && !ek[NSTG-2];
        n_checks++;
        if (kill_o !== ek || rf_wr_en !== erf || mem_acc_en !== emem) begin
            n_fail++;
            $display("FAIL %s: kill=%b rf=%b mem=%b expected kill=%b rf=%b mem=%b",
                     tag, kill_o, rf_wr_en, mem_acc_en, ek, erf, emem);
        end
        @(posedge clk);
        if (!rst_n) begin
            mq.delete();
            for (int s = 1; s < NSTG; s++) mq.push_back(1'b1);
            hold_left = RST_HOLD;
        end else begin
            mq.delete();
            for (int s = 0; s < NSTG - 1; s++) mq.push_back(ek[s]);
            if (hold_left > 0) hold_left--;
        end
        @(negedge clk);
    endtask

    task automatic drive(input logic res, input logic tk, input logic sq,
                         input logic ex);
        br_resolve   = res;
        br_taken     = tk;
        br_squash_en = sq;
        exc_req      = ex;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0);
            wb_wr_req   = 1'b1;
            mem_acc_req = 1'b1;
            step(tag);
        end
    endtask

    task automatic random_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
            wb_wr_req   = 1'($urandom_range(0, 1));
            mem_acc_req = 1'($urandom_range(0, 1));
            step(tag);
        end
    endtask

    initial begin
        for (int s = 1; s < NSTG; s++) mq.push_back(1'b1);
        hold_left = RST_HOLD;
        @(negedge clk);
        // R1: reset held with noisy inputs
        rst_n = 1'b0;
        random_cycles(4, "R1 reset flush");
        rst_n = 1'b1;
        // R2: drain after release, enables requested every cycle
        idle(8, "R2 post-reset drain");
        // R3 then R5: untaken squash, marks follow the slots
        drive(1'b1, 1'b0, 1'b1, 1'b0); step("R3 untaken squash");
        idle(5, "R5 slot marks travel");
        // R4: taken squashing branch
        drive(1'b1, 1'b1, 1'b1, 1'b0); step("R4 taken squashing branch");
        idle(5, "R4 taken aftermath");
        // R4: non-squashing untaken branch
        drive(1'b1, 1'b0, 1'b0, 1'b0); step("R4 non-squashing branch");
        idle(5, "R4 non-squashing aftermath");
        // R9: flags without resolve strobe
        drive(1'b0, 1'b0, 1'b1, 1'b0); step("R9 flags without resolve");
        drive(1'b0, 1'b1, 1'b1, 1'b0); step("R9 flags without resolve");
        idle(5, "R9 aftermath");
        // R6: exception alone
        drive(1'b0, 1'b0, 1'b0, 1'b1); step("R6 exception flush");
        idle(5, "R6 exception drain");
        // R7: exception with untaken squash
        drive(1'b1, 1'b0, 1'b1, 1'b1); step("R7 exception plus squash");
        idle(5, "R7 union drain");
        // R5: back-to-back squashes
        drive(1'b1, 1'b0, 1'b1, 1'b0); step("R5 back-to-back squash");
        drive(1'b1, 1'b0, 1'b1, 1'b0); step("R5 back-to-back squash");
        idle(5, "R5 back-to-back drain");
        // R8: random traffic with gated enables
        random_cycles(400, "R8 random traffic");
        // R1, R2: reset mid-run, then drain again
        rst_n = 1'b0;
        random_cycles(2, "R1 mid-run reset");
        rst_n = 1'b1;
        idle(8, "R2 second drain");
        random_cycles(200, "R5 random traffic");
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule